// File: doc/BRIEF.md
# Set/Clear Interrupt Mask and Priority Register File

This block holds a small set of interrupt control registers of two kinds. Mask registers are made of 1-bit fields. Priority registers are made of multi-bit fields. Software reaches each register through a simple write and read port. A register configured as dual-address has a set address and a clear address. A write to the set address ORs the data into the stored value. A write to the clear address removes the data bits from it. A priority register configured as single-address is overwritten by each write. Every address also answers at an alias, which differs only in one fixed address bit.

Each write compares the old and new register contents one field at a time. Every field that changed sends an enable or disable strobe toward the interrupt identifier mapped to that field's slot. The identifiers come from a parameter table. An identifier that names a group, rather than a source, passes its strobe along a linked chain of member sources. The strobes leave one per cycle on a strobe port. While strobes remain to be sent, a busy flag is raised and any write that arrives is dropped.

Top module: `intc_maskprio_regs`

## Requirements
- R1: A write to the set address of a dual-address register stores the old value ORed with the write data.
- R2: A write to the clear address of a dual-address register stores the old value ANDed with the inverted write data.
- R3: A write to a single-address priority register replaces the stored value with the write data.
- R4: `rd_data` shows the stored value of the register matching `rd_addr`, at its set or its clear address. An address that matches no register reads as zero, and a write to such an address changes nothing.
- R5: Flipping address bit 7 (ALIAS_BIT) reaches the same register, for both reads and writes.
- R6: Mask registers have 1-bit fields. Priority registers have 4-bit fields (PRIO_FW). Slot 0 is the most significant field. Only fields whose value changed produce strobes.
- R7: `stb_en` is 1 when the field's new value is nonzero, and 0 when the new value is zero.
- R8: A field mapped to identifier 0 emits no strobe. Neither does an identifier that is neither a source nor the head of a chain.
- R9: A field mapped to a group identifier emits one strobe for each chain member, in chain order, all with the same polarity. A member that a field addresses directly emits only its own strobe.
- R10: Strobes go out in ascending slot order, one per cycle. The first strobe is valid in the cycle right after the clock edge that accepts the write.
- R11: While `busy` is high, writes are ignored: the registers keep their values and no extra strobes appear. `busy` falls once the last strobe has been sent.
- R12: Reset clears every register to zero and holds `busy` and `stb_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | REG_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | REG_W | Stored value at rd_addr (combinational) |
| busy | output | 1 | Strobes still pending; writes are dropped |
| stb_valid | output | 1 | Strobe present this cycle |
| stb_id | output | ID_W | Target source identifier |
| stb_en | output | 1 | 1 = enable, 0 = disable |

## Verification
The hardest case to reach is a single write that changes several fields, where one field maps to a group and another field maps directly to one of that group's members. Only this case shows whether the chain is followed solely when entered through its head. The stimulus first builds up register contents, then clears or sets several bits in one write. It records every strobe together with its cycle number, so the bench can check both the order and the back-to-back timing. A second write is held on the port during that burst, and a readback afterwards shows whether the dropped write left the register untouched.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;

   typedef enum logic [1:0] {
      WR_NONE,
      WR_OR,
      WR_ANDN,
      WR_LOAD
   } wr_kind_e;

   localparam int DEF_IDS = 32;
   localparam int DEF_IDW = 5;

   // Default chain table: group 20 -> 3 -> 4 -> 5, group 21 -> 7 -> 8
   function automatic logic [DEF_IDS*DEF_IDW-1:0] def_next_table();
      logic [DEF_IDS*DEF_IDW-1:0] t;
      t = '0;
      t[20*DEF_IDW +: DEF_IDW] = 5'd3;
      t[3*DEF_IDW  +: DEF_IDW] = 5'd4;
      t[4*DEF_IDW  +: DEF_IDW] = 5'd5;
      t[21*DEF_IDW +: DEF_IDW] = 5'd7;
      t[7*DEF_IDW  +: DEF_IDW] = 5'd8;
      return t;
   endfunction

endpackage

// File: rtl/intc_addr_match.sv
module intc_addr_match
   import intc_regs_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                ALIAS_BIT = 7,
   parameter logic [ADDR_W-1:0] SET_ADDR  = '0,
   parameter logic [ADDR_W-1:0] CLR_ADDR  = '0,
   parameter bit                DUAL      = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output wr_kind_e          kind
);
   localparam logic [ADDR_W-1:0] FOLD = ~(ADDR_W'(1) << ALIAS_BIT);

   logic set_hit;
   logic clr_hit;

   if (ALIAS_BIT >= ADDR_W) begin : g_bad_alias
      $error("ALIAS_BIT must lie inside the address");
   end

   assign set_hit = (addr & FOLD) == (SET_ADDR & FOLD);

   if (DUAL) begin : g_dual
      assign clr_hit = (addr & FOLD) == (CLR_ADDR & FOLD);
   end else begin : g_single
      assign clr_hit = 1'b0;
   end

   always_comb begin
      if (set_hit)      kind = DUAL ? WR_OR : WR_LOAD;
      else if (clr_hit) kind = WR_ANDN;
      else              kind = WR_NONE;
   end

endmodule

// File: rtl/intc_field_diff.sv
module intc_field_diff #(
   parameter int REG_W = 8,
   parameter int FW    = 1
) (
   input  logic [REG_W-1:0] old_v,
   input  logic [REG_W-1:0] new_v,
   output logic [REG_W-1:0] chg,
   output logic [REG_W-1:0] nz
);
   localparam int NF = REG_W / FW;

   if (REG_W % FW != 0) begin : g_bad_fw
      $error("field width must divide the register width");
   end

   // slot s holds the s-th field counted from the most significant end
   for (genvar s = 0; s < REG_W; s++) begin : g_slot
      if (s < NF) begin : g_live
         logic [FW-1:0] f_old;
         logic [FW-1:0] f_new;
         assign f_old  = old_v[(NF-1-s)*FW +: FW];
         assign f_new  = new_v[(NF-1-s)*FW +: FW];
         assign chg[s] = f_old != f_new;
         assign nz[s]  = |f_new;
      end else begin : g_pad
         assign chg[s] = 1'b0;
         assign nz[s]  = 1'b0;
      end
   end

endmodule

// File: rtl/intc_strobe_walker.sv
module intc_strobe_walker #(
   parameter int                                 REG_W     = 8,
   parameter int                                 NUM_REGS  = 3,
   parameter int                                 ID_W      = 5,
   parameter int                                 NUM_IDS   = 32,
   parameter logic [NUM_REGS*REG_W*ID_W-1:0]     FIELD_MAP = '0,
   parameter logic [NUM_IDS*ID_W-1:0]            NEXT_ID   = '0,
   parameter logic [NUM_IDS-1:0]                 IS_SRC    = '0,
   localparam int                                RIW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [RIW-1:0]   start_reg,
   input  logic [REG_W-1:0] start_chg,
   input  logic [REG_W-1:0] start_nz,
   output logic             busy,
   output logic             stb_valid,
   output logic [ID_W-1:0]  stb_id,
   output logic             stb_en
);
   localparam int SW = (REG_W > 1) ? $clog2(REG_W) : 1;

   logic             act_q, grp_q, pol_q;
   logic [ID_W-1:0]  cur_q;
   logic [REG_W-1:0] pend_q, nz_q;
   logic [RIW-1:0]   reg_q;

   logic [REG_W-1:0] src_m, src_nz;
   logic [RIW-1:0]   src_reg;
   logic [SW-1:0]    k;
   logic [ID_W-1:0]  load_id, next_id;
   logic             chain_go;

   always_comb begin
      src_m   = start ? start_chg : pend_q;
      src_nz  = start ? start_nz  : nz_q;
      src_reg = start ? start_reg : reg_q;
      k = '0;
      for (int i = REG_W - 1; i >= 0; i--) begin
         if (src_m[i]) k = SW'(i);
      end
      load_id  = FIELD_MAP[(int'(src_reg) * REG_W + int'(k)) * ID_W +: ID_W];
      next_id  = NEXT_ID[int'(cur_q) * ID_W +: ID_W];
      chain_go = act_q && (cur_q != '0) && (grp_q || !IS_SRC[cur_q]) && (next_id != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         grp_q  <= 1'b0;
         pol_q  <= 1'b0;
         cur_q  <= '0;
         pend_q <= '0;
         nz_q   <= '0;
         reg_q  <= '0;
      end else if (start || (act_q && !chain_go)) begin
         // take the next changed field, or go idle when none is left
         act_q  <= |src_m;
         cur_q  <= load_id;
         pol_q  <= src_nz[k];
         grp_q  <= 1'b0;
         pend_q <= src_m & ~(REG_W'(1) << k);
         nz_q   <= src_nz;
         reg_q  <= src_reg;
      end else if (chain_go) begin
         cur_q <= next_id;
         grp_q <= 1'b1;
      end
   end

   assign busy      = act_q | (|pend_q);
   assign stb_valid = act_q && (cur_q != '0) && IS_SRC[cur_q];
   assign stb_id    = cur_q;
   assign stb_en    = pol_q;

endmodule

// File: rtl/intc_maskprio_regs.sv
module intc_maskprio_regs
   import intc_regs_pkg::*;
#(
   parameter int  ADDR_W    = 8,
   parameter int  REG_W     = 8,
   parameter int  NUM_REGS  = 3,
   parameter int  PRIO_FW   = 4,
   parameter int  NUM_IDS   = 32,
   parameter int  ALIAS_BIT = 7,
   localparam int ID_W      = $clog2(NUM_IDS),
   localparam int RIW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   parameter logic [NUM_REGS-1:0]             REG_IS_PRIO = 3'b110,
   parameter logic [NUM_REGS-1:0]             REG_DUAL    = 3'b011,
   parameter logic [NUM_REGS*ADDR_W-1:0]      SET_ADDRS   = {8'h20, 8'h18, 8'h10},
   parameter logic [NUM_REGS*ADDR_W-1:0]      CLR_ADDRS   = {8'h00, 8'h1C, 8'h14},
   parameter logic [NUM_REGS*REG_W*ID_W-1:0]  FIELD_MAP   = {
      5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd30, 5'd12,
      5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd21, 5'd11,
      5'd10, 5'd9, 5'd6, 5'd20, 5'd0, 5'd3, 5'd2, 5'd1},
   parameter logic [NUM_IDS*ID_W-1:0]         NEXT_ID     = def_next_table(),
   parameter logic [NUM_IDS-1:0]              IS_SRC      = 32'h0000_1FFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output logic              busy,
   output logic              stb_valid,
   output logic [ID_W-1:0]   stb_id,
   output logic              stb_en
);
   if (NUM_IDS != (1 << ID_W)) begin : g_bad_ids
      $error("NUM_IDS must be a power of two");
   end
   if (REG_W % PRIO_FW != 0) begin : g_bad_prio
      $error("PRIO_FW must divide REG_W");
   end

   logic [REG_W-1:0]          val_q  [NUM_REGS];
   logic [REG_W-1:0]          nxt_v  [NUM_REGS];
   logic [REG_W-1:0]          chg_v  [NUM_REGS];
   logic [REG_W-1:0]          nz_v   [NUM_REGS];
   wr_kind_e                  wr_kind[NUM_REGS];
   wr_kind_e                  rd_kind[NUM_REGS];
   logic [NUM_REGS-1:0]       wr_hit, rd_hit;
   logic [NUM_REGS*REG_W-1:0] regs_flat;
   logic [RIW-1:0]            sel;
   logic                      found, accept;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      if (!REG_IS_PRIO[r] && !REG_DUAL[r]) begin : g_bad_mask
         $error("mask registers need a set and a clear address");
      end

      intc_addr_match #(
         .ADDR_W(ADDR_W), .ALIAS_BIT(ALIAS_BIT),
         .SET_ADDR(SET_ADDRS[r*ADDR_W +: ADDR_W]),
         .CLR_ADDR(CLR_ADDRS[r*ADDR_W +: ADDR_W]),
         .DUAL(REG_DUAL[r])
      ) u_wmatch (.addr(wr_addr), .kind(wr_kind[r]));

      intc_addr_match #(
         .ADDR_W(ADDR_W), .ALIAS_BIT(ALIAS_BIT),
         .SET_ADDR(SET_ADDRS[r*ADDR_W +: ADDR_W]),
         .CLR_ADDR(CLR_ADDRS[r*ADDR_W +: ADDR_W]),
         .DUAL(REG_DUAL[r])
      ) u_rmatch (.addr(rd_addr), .kind(rd_kind[r]));

      assign wr_hit[r] = wr_kind[r] != WR_NONE;
      assign rd_hit[r] = rd_kind[r] != WR_NONE;

      always_comb begin
         case (wr_kind[r])
            WR_OR:   nxt_v[r] = val_q[r] | wr_data;
            WR_ANDN: nxt_v[r] = val_q[r] & ~wr_data;
            WR_LOAD: nxt_v[r] = wr_data;
            default: nxt_v[r] = val_q[r];
         endcase
      end

      if (REG_IS_PRIO[r]) begin : g_prio
         intc_field_diff #(.REG_W(REG_W), .FW(PRIO_FW)) u_diff (
            .old_v(val_q[r]), .new_v(nxt_v[r]), .chg(chg_v[r]), .nz(nz_v[r]));
      end else begin : g_mask
         intc_field_diff #(.REG_W(REG_W), .FW(1)) u_diff (
            .old_v(val_q[r]), .new_v(nxt_v[r]), .chg(chg_v[r]), .nz(nz_v[r]));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          val_q[r] <= '0;
         else if (accept && sel == RIW'(r))   val_q[r] <= nxt_v[r];
      end

      assign regs_flat[r*REG_W +: REG_W] = val_q[r];
   end

   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (wr_hit[r] && !found) begin
            sel   = RIW'(r);
            found = 1'b1;
         end
      end
      accept = wr_en && !busy && found;
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rd_hit[r]) rd_data = rd_data | val_q[r];
      end
   end

   intc_strobe_walker #(
      .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ID_W(ID_W), .NUM_IDS(NUM_IDS),
      .FIELD_MAP(FIELD_MAP), .NEXT_ID(NEXT_ID), .IS_SRC(IS_SRC)
   ) u_walker (
      .clk(clk), .rst_n(rst_n),
      .start(accept), .start_reg(sel),
      .start_chg(chg_v[sel]), .start_nz(nz_v[sel]),
      .busy(busy), .stb_valid(stb_valid), .stb_id(stb_id), .stb_en(stb_en)
   );

endmodule

// File: rtl/intc_maskprio_regs_chk.sv
module intc_maskprio_regs_chk #(
   parameter int                 NUM_IDS  = 32,
   parameter int                 ID_W     = 5,
   parameter int                 REG_BITS = 24,
   parameter logic [NUM_IDS-1:0] IS_SRC   = '0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                busy,
   input logic                stb_valid,
   input logic [ID_W-1:0]     stb_id,
   input logic [REG_BITS-1:0] regs_flat
);

   // R8
   stb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_valid |-> (stb_id != '0) && IS_SRC[stb_id]);

   // R11
   busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(regs_flat));

   // R10
   stb_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_valid |-> busy);

   // R10
   burst_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_en));

   // R11
   idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en) |=> !busy);

   // R12
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (regs_flat == '0) && !busy && !stb_valid);

endmodule

bind intc_maskprio_regs intc_maskprio_regs_chk #(
   .NUM_IDS(NUM_IDS), .ID_W(ID_W), .REG_BITS(NUM_REGS*REG_W), .IS_SRC(IS_SRC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
   .stb_valid(stb_valid), .stb_id(stb_id), .regs_flat(regs_flat)
);

// File: tb/intc_maskprio_regs_test.sv
`timescale 1ns/1ps
module intc_maskprio_regs_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       busy, stb_valid, stb_en;
   logic [4:0] stb_id;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int cap_n = 0;
   int cap_id [32];
   int cap_en [32];
   int cap_cyc[32];
   int wr_edge = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   intc_maskprio_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
      .stb_valid(stb_valid), .stb_id(stb_id), .stb_en(stb_en));

   always @(negedge clk) begin
      if (rst_n && stb_valid && cap_n < 32) begin
         cap_id[cap_n]  = int'(stb_id);
         cap_en[cap_n]  = int'(stb_en);
         cap_cyc[cap_n] = cyc;
         cap_n = cap_n + 1;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cap_n   = 0;
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      wr_edge = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output int v);
      @(negedge clk);
      rd_addr = a;
      #1 v = int'(rd_data);
   endtask

   task automatic exp_s(input string tag, input int i, input int id, input int en);
      check({tag, " id"}, cap_id[i], id);
      check({tag, " en"}, cap_en[i], en);
   endtask

   // {write addr, write data, read addr, expected read}
   localparam logic [31:0] VEC [9] = '{
      32'h10_81_10_81,   // R1 set OR
      32'h90_42_14_C3,   // R5 alias set, R4 read at clear address
      32'h14_81_94_42,   // R2 clear AND-NOT, read via alias
      32'h18_A0_1C_A0,   // R1 priority register set
      32'h9C_20_18_80,   // R2 priority clear via alias
      32'h20_3C_A0_3C,   // R3 direct load
      32'h20_05_20_05,   // R3 overwrite, not OR
      32'h44_FF_10_42,   // R4 unmapped write has no effect
      32'h44_00_44_00    // R4 unmapped read is zero
   };

   initial begin
      int v;
      #1000000;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_up();
   end

   initial begin
      int v;
      // R12 reset state
      repeat (3) @(negedge clk);
      check("R12 busy in reset", int'(busy), 0);
      check("R12 strobe in reset", int'(stb_valid), 0);
      rst_n = 1'b1;
      rd(8'h10, v); check("R12 reg0 zero", v, 0);
      rd(8'h18, v); check("R12 reg1 zero", v, 0);
      rd(8'h20, v); check("R12 reg2 zero", v, 0);

      for (int i = 0; i < 9; i++) begin
         wr(VEC[i][31:24], VEC[i][23:16]);
         rd(VEC[i][15:8], v);
         check($sformatf("vector %0d R1 R2 R3 R4 R5", i), v, int'(VEC[i][7:0]));
      end

      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R6 R7 R8 slot 0 id1 enable, slot 3 id0 dropped
      wr(8'h10, 8'h90);
      check("R8 count id0 dropped", cap_n, 1);
      exp_s("R6 slot0", 0, 1, 1);
      check("R10 first strobe cycle", cap_cyc[0], wr_edge);

      // R9 group 20 chain
      wr(8'h10, 8'h08);
      check("R9 chain count", cap_n, 3);
      exp_s("R9 member a", 0, 3, 1);
      exp_s("R9 member b", 1, 4, 1);
      exp_s("R9 member c", 2, 5, 1);

      // R7 disables for slots 0,3,4
      wr(8'h14, 8'hFF);
      check("R7 clear count", cap_n, 4);
      exp_s("R7 disable id1", 0, 1, 0);
      exp_s("R7 disable chain a", 1, 3, 0);
      exp_s("R7 disable chain b", 2, 4, 0);
      exp_s("R7 disable chain c", 3, 5, 0);

      // R9 direct member does not follow chain
      wr(8'h10, 8'h20);
      check("R9 direct member count", cap_n, 1);
      exp_s("R9 direct member", 0, 3, 1);

      // R10 several fields back to back
      wr(8'h10, 8'h47);
      check("R10 multi count", cap_n, 4);
      exp_s("R10 order 0", 0, 2, 1);
      exp_s("R10 order 1", 1, 6, 1);
      exp_s("R10 order 2", 2, 9, 1);
      exp_s("R10 order 3", 3, 10, 1);
      check("R10 first cycle", cap_cyc[0], wr_edge);
      check("R10 back to back", cap_cyc[3], cap_cyc[0] + 3);

      // R6 priority fields, slot1 group 21
      wr(8'h18, 8'h31);
      check("R6 prio count", cap_n, 3);
      exp_s("R6 prio slot0", 0, 11, 1);
      exp_s("R9 group21 a", 1, 7, 1);
      exp_s("R9 group21 b", 2, 8, 1);

      // R7 field nonzero to nonzero still enables
      wr(8'h18, 8'h02);
      check("R7 re-enable count", cap_n, 2);
      exp_s("R7 re-enable a", 0, 7, 1);
      exp_s("R7 re-enable b", 1, 8, 1);

      wr(8'h1C, 8'h30);
      check("R7 prio disable count", cap_n, 1);
      exp_s("R7 prio disable", 0, 11, 0);

      // R3 R8 direct register, id30 reserved
      wr(8'h20, 8'h5A);
      check("R8 reserved count", cap_n, 1);
      exp_s("R3 direct slot0", 0, 12, 1);
      wr(8'hA0, 8'h0A);
      check("R5 alias direct count", cap_n, 1);
      exp_s("R5 alias direct", 0, 12, 0);
      rd(8'h20, v); check("R3 direct value", v, 8'h0A);

      // R11 write held during burst is dropped
      @(negedge clk);
      cap_n = 0;
      wr_en = 1'b1; wr_addr = 8'h14; wr_data = 8'h47;
      @(negedge clk);
      check("R11 busy during burst", int'(busy), 1);
      wr_addr = 8'h10; wr_data = 8'h80;
      repeat (2) @(negedge clk);
      wr_en = 1'b0;
      while (busy) @(negedge clk);
      check("R11 burst count", cap_n, 4);
      exp_s("R11 burst 0", 0, 2, 0);
      exp_s("R11 burst 3", 3, 10, 0);
      rd(8'h10, v); check("R11 dropped write", v, 8'h20);
      repeat (2) @(negedge clk);
      check("R11 idle after burst", int'(busy), 0);

      finish_up();
   end

endmodule